// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block holds the interrupt state of one processor. It keeps three 256-bit vectors, one bit per interrupt vector. The pending set records vectors that have been requested. The in-service set records vectors the processor has taken and not yet retired. The trigger set records, for each vector, whether its last request was level-sensitive. Requests arrive on a single port as a vector number and a trigger kind. The processor takes interrupts through a one-cycle acknowledge handshake, and it retires them with an end-of-interrupt strobe.

Whether a pending vector may interrupt depends on a processor priority. This priority is formed from a task-priority register and from the class (upper four bits) of the highest vector in service. A spurious/enable register does three things: it gates the whole block on and off, it supplies the vector returned when an acknowledge finds its candidate blocked, and it can suppress the end-of-interrupt broadcast. That broadcast is a one-cycle pulse carrying the vector of a retired level-triggered interrupt, so that the sources of level-sensitive lines can re-evaluate them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all three vector sets are empty, the task priority is 0, the spurious/enable register holds 0x0FF (so the block is disabled), `irqOut` is low and `pprOut` is 0.
- R2: A request (`reqValid`) sets the pending bit of `reqVector`. It sets that vector's trigger bit when `reqLevel` is 1 (level) and clears it when `reqLevel` is 0 (edge). The new state is visible from the next cycle.
- R3: Within a set, the highest-priority entry is the highest-numbered set bit. A vector's priority class is its bits [7:4].
- R4: `pprOut` equals the task priority when task-priority bits [7:4] are at least the class of the highest in-service vector (0 if none is in service). Otherwise it equals that class shifted left by 4.
- R5: `irqOut` is high in the same cycle whenever the block is enabled, some vector is pending, and either `pprOut` is 0 or the class of the highest pending vector is strictly greater than `pprOut[7:4]`.
- R6: While spurious/enable bit 8 is 0, `irqOut` is low, an acknowledge gives `ackValid` low, and an acknowledge changes no state.
- R7: An acknowledge that finds a qualifying vector gives `ackValid` high and that vector on `ackVector` in the same cycle. From the next cycle the vector is no longer pending and is in service.
- R8: An acknowledge while enabled and with the highest pending vector blocked gives `ackValid` high with spurious/enable bits [7:0], and it changes no state. With nothing pending it gives `ackValid` low.
- R9: End-of-interrupt clears the highest in-service bit of the state before the edge and does nothing when none is set. A vector taken by an acknowledge in the same cycle still enters service.
- R10: In the same cycle as an end-of-interrupt that retires a vector whose trigger bit is 1, `bcastValid` pulses with that vector on `bcastVector`, unless spurious/enable bit 12 is 1.
- R11: A write to the spurious/enable register keeps only bits [8:0] and bit 12. All other written bits have no effect.
- R12: When a request and a successful acknowledge name the same vector in one cycle, the acknowledge applies first, so the vector ends up both in service and pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Interrupt request strobe |
| reqVector | input | 8 | Requested vector |
| reqLevel | input | 1 | 1 for a level-triggered request, 0 for edge |
| tprWrEn | input | 1 | Task-priority write enable |
| tprWrData | input | 8 | Task-priority write value |
| svrWrEn | input | 1 | Spurious/enable register write enable |
| svrWrData | input | 16 | Spurious/enable write value (bits [7:0] spurious vector, bit 8 enable, bit 12 broadcast suppress) |
| ackReq | input | 1 | Acknowledge request |
| ackValid | output | 1 | Acknowledge returned a vector |
| ackVector | output | 8 | Returned vector |
| eoiStrobe | input | 1 | End-of-interrupt strobe |
| irqOut | output | 1 | Interrupt request level to the processor |
| bcastValid | output | 1 | End-of-interrupt broadcast pulse |
| bcastVector | output | 8 | Vector carried by the broadcast |
| pprOut | output | 8 | Current processor priority |

## Verification
On every cycle, the assertions check the following. The disabled state keeps the request line and the handshake quiet. A non-taking acknowledge returns the spurious vector. The processor priority never falls below the task priority. Broadcasts come only from retired level vectors while suppression is clear. Each request, take and retire leaves the expected bits in the state sets, and the sets stay still when no strobe is active. Other behaviours depend on the stimulus history, and only the bench's scenarios and its cycle-by-cycle model can show them. These include the exact priority ordering among several pending vectors, the strict class comparison against the task priority, the ordering when a request and an acknowledge name the same vector, and the masking of unused spurious/enable bits.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  parameter int VEC_W = 8;
  parameter int CLS_W = 4;
  parameter int SVR_W = 16;
  parameter int SVR_KEEP_W = 13;
  localparam logic [SVR_KEEP_W-1:0] SVR_KEEP = 13'h11FF;
  localparam logic [SVR_KEEP_W-1:0] SVR_RESET = 13'h00FF;
  localparam int SVR_EN_BIT = 8;
  localparam int SVR_SUP_BIT = 12;

  typedef struct packed {
    logic             post;
    logic             postLevel;
    logic [VEC_W-1:0] postVec;
    logic             take;
    logic [VEC_W-1:0] takeVec;
    logic             retire;
    logic [VEC_W-1:0] retireVec;
  } dpStrobe_t;
endpackage

// File: rtl/vec_prio_enc.sv
module vec_prio_enc #(
  parameter int WIDTH = 256,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Highest-numbered set bit wins (R3).
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int VW = VEC_W,
  localparam int NV = 1 << VW
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  output logic          irrAny,
  output logic [VW-1:0] irrTop,
  output logic          isrAny,
  output logic [VW-1:0] isrTop,
  output logic          isrTopLevel
);
  logic [NV-1:0] irr, isr, tmr;
  logic [NV-1:0] postMask, takeMask, retireMask;

  assign postMask   = strb.post   ? (NV'(1) << strb.postVec)   : '0;
  assign takeMask   = strb.take   ? (NV'(1) << strb.takeVec)   : '0;
  assign retireMask = strb.retire ? (NV'(1) << strb.retireVec) : '0;

  // Two identical encoders: pending set and in-service set.
  for (genvar g = 0; g < 2; g++) begin : g_enc
    logic [NV-1:0] src;
    logic          anyBit;
    logic [VW-1:0] topIdx;
    assign src = (g == 0) ? irr : isr;
    vec_prio_enc #(.WIDTH(NV), .IDX_W(VW)) u_enc (
      .bits(src), .any(anyBit), .idx(topIdx)
    );
  end

  assign irrAny      = g_enc[0].anyBit;
  assign irrTop      = g_enc[0].topIdx;
  assign isrAny      = g_enc[1].anyBit;
  assign isrTop      = g_enc[1].topIdx;
  assign isrTopLevel = tmr[isrTop];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      // acknowledge clears first, a same-cycle request sets again (R12)
      irr <= (irr & ~takeMask) | postMask;
      isr <= (isr & ~retireMask) | takeMask;
      if (strb.post) tmr[strb.postVec] <= strb.postLevel;
    end
  end

  p_post_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.post |=> irr[$past(strb.postVec)] &&
                  (tmr[$past(strb.postVec)] == $past(strb.postLevel)));

  p_take_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.take && !(strb.post && strb.postVec == strb.takeVec)
      |=> !irr[$past(strb.takeVec)] && isr[$past(strb.takeVec)]);

  p_retire_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.retire && !(strb.take && strb.takeVec == strb.retireVec)
      |=> !isr[$past(strb.retireVec)]);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.post && !strb.take && !strb.retire
      |=> $stable(irr) && $stable(isr) && $stable(tmr));
endmodule

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import irq_prio_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int CW = CLS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VW-1:0]    reqVector,
  input  logic             reqLevel,
  input  logic             tprWrEn,
  input  logic [VW-1:0]    tprWrData,
  input  logic             svrWrEn,
  input  logic [SVR_W-1:0] svrWrData,
  input  logic             ackReq,
  input  logic             eoiStrobe,
  input  logic             irrAny,
  input  logic [VW-1:0]    irrTop,
  input  logic             isrAny,
  input  logic [VW-1:0]    isrTop,
  input  logic             isrTopLevel,
  output dpStrobe_t        strb,
  output logic             irqOut,
  output logic             ackValid,
  output logic [VW-1:0]    ackVector,
  output logic             bcastValid,
  output logic [VW-1:0]    bcastVector,
  output logic [VW-1:0]    pprOut
);
  logic [VW-1:0]         tprReg;
  logic [SVR_KEEP_W-1:0] svrReg;
  logic [CW-1:0]         isrClass, tprClass, irrClass;
  logic                  swEnable, suppress, qualify;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tprReg <= '0;
      svrReg <= SVR_RESET;
    end else begin
      if (tprWrEn) tprReg <= tprWrData;
      if (svrWrEn) svrReg <= svrWrData[SVR_KEEP_W-1:0] & SVR_KEEP;
    end
  end

  assign swEnable = svrReg[SVR_EN_BIT];
  assign suppress = svrReg[SVR_SUP_BIT];
  assign isrClass = isrAny ? isrTop[VW-1 -: CW] : '0;
  assign tprClass = tprReg[VW-1 -: CW];
  assign irrClass = irrTop[VW-1 -: CW];

  always_comb begin
    if (tprClass >= isrClass) pprOut = tprReg;
    else                      pprOut = {isrClass, {(VW-CW){1'b0}}};
  end

  assign qualify = swEnable && irrAny &&
                   ((pprOut == '0) || (irrClass > pprOut[VW-1 -: CW]));
  assign irqOut  = qualify;

  always_comb begin
    ackValid  = ackReq && swEnable && irrAny;
    ackVector = qualify ? irrTop : svrReg[VW-1:0];
  end

  always_comb begin
    strb           = '0;
    strb.post      = reqValid;
    strb.postLevel = reqLevel;
    strb.postVec   = reqVector;
    strb.take      = ackReq && qualify;
    strb.takeVec   = irrTop;
    strb.retire    = eoiStrobe && isrAny;
    strb.retireVec = isrTop;
  end

  assign bcastValid  = strb.retire && isrTopLevel && !suppress;
  assign bcastVector = isrTop;

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !svrReg[SVR_EN_BIT] |-> !irqOut && !ackValid && !strb.take);

  p_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && !strb.take |-> ackVector == svrReg[VW-1:0]);

  p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    pprOut[VW-1 -: CW] >= tprReg[VW-1 -: CW]);

  p_bcast_r10: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid |-> strb.retire && isrTopLevel && !svrReg[SVR_SUP_BIT] &&
                   bcastVector == strb.retireVec);

  p_svr_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    svrWrEn |=> (svrReg & ~SVR_KEEP) == '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             reqLevel,
  input  logic             tprWrEn,
  input  logic [VEC_W-1:0] tprWrData,
  input  logic             svrWrEn,
  input  logic [SVR_W-1:0] svrWrData,
  input  logic             ackReq,
  output logic             ackValid,
  output logic [VEC_W-1:0] ackVector,
  input  logic             eoiStrobe,
  output logic             irqOut,
  output logic             bcastValid,
  output logic [VEC_W-1:0] bcastVector,
  output logic [VEC_W-1:0] pprOut
);
  dpStrobe_t        strb;
  logic             irrAny, isrAny, isrTopLevel;
  logic [VEC_W-1:0] irrTop, isrTop;

  irq_prio_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .svrWrEn(svrWrEn), .svrWrData(svrWrData),
    .ackReq(ackReq), .eoiStrobe(eoiStrobe),
    .irrAny(irrAny), .irrTop(irrTop),
    .isrAny(isrAny), .isrTop(isrTop), .isrTopLevel(isrTopLevel),
    .strb(strb), .irqOut(irqOut),
    .ackValid(ackValid), .ackVector(ackVector),
    .bcastValid(bcastValid), .bcastVector(bcastVector),
    .pprOut(pprOut)
  );

  irq_prio_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .irrAny(irrAny), .irrTop(irrTop),
    .isrAny(isrAny), .isrTop(isrTop), .isrTopLevel(isrTopLevel)
  );
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqLevel = 0, tprWrEn = 0, svrWrEn = 0;
  logic        ackReq = 0, eoiStrobe = 0;
  logic [7:0]  reqVector = 0, tprWrData = 0;
  logic [15:0] svrWrData = 0;
  logic        ackValid, irqOut, bcastValid;
  logic [7:0]  ackVector, bcastVector, pprOut;

  int checks = 0, failures = 0;
  bit [255:0] mIrr, mIsr, mTmr;
  int mTpr, mSvr;
  bit lastAckValid, lastBcValid;
  int lastAckVec, lastBcVec;

  always #5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .tprWrEn(tprWrEn), .tprWrData(tprWrData),
    .svrWrEn(svrWrEn), .svrWrData(svrWrData), .ackReq(ackReq),
    .ackValid(ackValid), .ackVector(ackVector), .eoiStrobe(eoiStrobe),
    .irqOut(irqOut), .bcastValid(bcastValid), .bcastVector(bcastVector),
    .pprOut(pprOut)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int topOf(bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int mPpr();
    int c = topOf(mIsr);
    if (c < 0) c = 0;
    c = c >> 4;
    if ((mTpr >> 4) >= c) return mTpr;
    return c << 4;
  endfunction

  function automatic bit mQual();
    int t = topOf(mIrr);
    int p = mPpr();
    if (!mSvr[8] || t < 0) return 0;
    return (p == 0) || ((t >> 4) > (p >> 4));
  endfunction

  // One clock: compare at negedge, advance the model at posedge.
  task automatic cycle();
    int it, st, expVec;
    bit q, expAv, expBv, doTake;
    @(negedge clk);
    it = topOf(mIrr);
    st = topOf(mIsr);
    q  = mQual();
    chk("R5 irqOut", irqOut, q);
    chk("R4 pprOut", pprOut, mPpr());
    lastAckValid = ackValid; lastAckVec = ackVector;
    lastBcValid = bcastValid; lastBcVec = bcastVector;
    doTake = 0;
    if (ackReq) begin
      expAv = mSvr[8] && (it >= 0);
      chk(!mSvr[8] ? "R6 ackValid" : (q ? "R7 ackValid" : "R8 ackValid"), ackValid, expAv);
      if (expAv) begin
        expVec = q ? it : (mSvr & 8'hFF);
        chk(q ? "R7 ackVector" : "R8 ackVector", ackVector, expVec);
      end
      doTake = q;
    end
    expBv = eoiStrobe && (st >= 0) && mTmr[st] && !mSvr[12];
    chk("R10 bcastValid", bcastValid, expBv);
    if (expBv) chk("R10 bcastVector", bcastVector, st);
    @(posedge clk);
    if (eoiStrobe && st >= 0) mIsr[st] = 1'b0;
    if (doTake) begin mIrr[it] = 1'b0; mIsr[it] = 1'b1; end
    if (reqValid) begin mIrr[reqVector] = 1'b1; mTmr[reqVector] = reqLevel; end
    if (tprWrEn) mTpr = tprWrData;
    if (svrWrEn) mSvr = svrWrData & 16'h11FF;
    #1;
    reqValid = 0; ackReq = 0; eoiStrobe = 0; tprWrEn = 0; svrWrEn = 0;
  endtask

  task automatic idle(); cycle(); endtask
  task automatic post(int v, bit lvl);
    reqValid = 1; reqVector = 8'(v); reqLevel = lvl; cycle();
  endtask
  task automatic ack(); ackReq = 1; cycle(); endtask
  task automatic eoi(); eoiStrobe = 1; cycle(); endtask
  task automatic wrTpr(int v); tprWrEn = 1; tprWrData = 8'(v); cycle(); endtask
  task automatic wrSvr(int v); svrWrEn = 1; svrWrData = 16'(v); cycle(); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int lfsr;
    mIrr = '0; mIsr = '0; mTmr = '0; mTpr = 0; mSvr = 'h0FF;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    idle();
    chk("R1 irqOut", irqOut, 0);
    chk("R1 pprOut", pprOut, 0);

    // R6 disabled block
    ack();
    chk("R6 ack while disabled", lastAckValid, 0);
    post('h31, 0);
    idle();
    chk("R6 irq while disabled", irqOut, 0);

    wrSvr('h01FF);
    idle();
    chk("R5 irq after enable", irqOut, 1);

    // R2/R3 ordering among several pending vectors
    post('h2F, 1);
    post('h30, 0);
    ack();
    chk("R3 highest pending", lastAckVec, 'h31);
    chk("R7 ack valid", lastAckValid, 1);
    idle();
    chk("R4 ppr from isr class", pprOut, 'h30);
    chk("R5 lower classes blocked", irqOut, 0);
    ack();
    chk("R8 spurious vector", lastAckVec, 'hFF);
    post('h52, 1);
    ack();
    chk("R7 higher class taken", lastAckVec, 'h52);
    eoi();
    chk("R10 level bcast", lastBcValid, 1);
    chk("R10 level bcast vec", lastBcVec, 'h52);
    eoi();
    chk("R10 edge no bcast", lastBcValid, 0);

    // R4/R5 task priority, strict class compare
    wrTpr('h30);
    idle();
    chk("R4 ppr from tpr", pprOut, 'h30);
    chk("R5 equal class blocked", irqOut, 0);
    wrTpr('h20);
    ack();
    chk("R7 take 0x30", lastAckVec, 'h30);
    eoi();
    ack();
    chk("R5 class 2 vs tpr 0x20 blocked", lastAckVec, 'hFF);
    wrTpr(0);
    ack();
    chk("R7 take 0x2F", lastAckVec, 'h2F);
    eoi();
    chk("R2 level trigger recorded", lastBcVec, 'h2F);
    eoi();
    chk("R9 empty eoi no bcast", lastBcValid, 0);

    // R11 masking of spurious/enable writes
    wrSvr('hE1FF);
    post('h05, 1);
    idle();
    chk("R11 enable kept", irqOut, 1);
    ack();
    eoi();
    chk("R11 bit12 clear -> bcast", lastBcValid, 1);
    wrSvr('h31AB);
    post('h80, 1);
    ack();
    eoi();
    chk("R11 suppression bit12", lastBcValid, 0);
    post('h10, 0);
    wrTpr('hF0);
    ack();
    chk("R11 spurious low byte", lastAckVec, 'hAB);
    wrTpr(0);
    ack();
    eoi();
    wrSvr('h01FF);

    // R12 same-cycle request and acknowledge of one vector
    post('h90, 0);
    reqValid = 1; reqVector = 8'h90; reqLevel = 0; ackReq = 1;
    cycle();
    chk("R12 ack vector", lastAckVec, 'h90);
    idle();
    chk("R12 repending blocked by isr", irqOut, 0);
    eoi();
    ack();
    chk("R12 vector pending again", lastAckVec, 'h90);
    eoi();

    // R6 disable with pending
    post('h70, 0);
    wrSvr('h00FF);
    ack();
    chk("R6 ack disabled with pending", lastAckValid, 0);
    wrSvr('h01FF);
    ack();
    eoi();

    // Mixed traffic, compared every cycle against the model
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      reqValid  = lfsr[2] & lfsr[5];
      reqVector = lfsr[15:8];
      reqLevel  = lfsr[16];
      ackReq    = lfsr[3];
      eoiStrobe = lfsr[4] & lfsr[7];
      if (lfsr[31:26] == 0) begin tprWrEn = 1; tprWrData = lfsr[23:16]; end
      if (lfsr[31:25] == 7'h7F) begin
        svrWrEn = 1;
        svrWrData = {lfsr[24:22], lfsr[20], 3'b000, lfsr[19:18] != 0, lfsr[17:10]};
      end
      cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule